// File: doc/BRIEF.md
# Variable-Entry Circular Event Buffer Manager

This block manages one circular buffer whose entries are whole events of varying length. The buffer memory has a main region followed directly by an overflow region. The overflow region is sized above the largest event, so an event that starts inside the main region can always be written as one unbroken block. The memory itself and the engine that moves the words are outside the block. The manager only hands out addresses and keeps track of space.

A producer presents a transfer descriptor: a word count and a continuation flag. The manager answers one cycle later. It either grants the transfer and gives its start address, or it reports the buffer as full and leaves its state untouched. A transfer flagged as a continuation belongs to the same event as the next transfer. The manager keeps the event's first address and a running sum of the counts. When the final transfer of an event is granted, the event's start address and total length go into a small read-pointer FIFO. The consumer reads the oldest event from the head of that FIFO, then pulses a release strobe, which returns that event's space to the buffer. Word contents are never inspected.

Top module: `evbuf_mgr`

## Requirements
- R1: While reset is high and on the cycle after it, grant, full and head_valid are 0 and wr_addr is 0. The first event starts at address 0.
- R2: A granted request raises grant for exactly the cycle after it. On that cycle wr_addr shows the write pointer at the time of the request. Events that end before MAIN_WORDS are packed back to back.
- R3: A transfer with xfer_more=1 leaves the event open. The next granted transfer starts directly after it. When the event closes, the FIFO entry holds the first transfer's address and the sum of all the event's counts.
- R4: When a closing transfer ends at or beyond address MAIN_WORDS, the next event starts at address 0.
- R5: A request is refused in two cases. With no wrap outstanding, it is refused if the write pointer plus the count exceeds MAIN_WORDS+OVF_WORDS. After a write-side wrap, it is refused if the write pointer plus the count exceeds the start of the oldest live event. A refused request changes no state.
- R6: A closing transfer (xfer_more=0) is refused while the FIFO holds FIFO_DEPTH entries. A continuation transfer that fits is still granted.
- R7: head_valid is 1 exactly while the FIFO is non-empty. head_addr and head_len show the oldest unreleased event, and events appear in completion order.
- R8: rel with head_valid=1 drops the head entry. Free space then reaches head_addr+head_len, or address 0 if that sum is at least MAIN_WORDS. rel with head_valid=0 has no effect.
- R9: Each request yields exactly one of grant or full on the next cycle. Neither is raised on a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer request, one cycle |
| xfer_words | input | CNT_W | Word count of the transfer |
| xfer_more | input | 1 | 1: the event continues in the next transfer |
| rel | input | 1 | Consumer releases the head event |
| grant | output | 1 | Request accepted (registered pulse) |
| full | output | 1 | Request refused for lack of space (registered pulse) |
| wr_addr | output | ADDR_W | Start address of the last granted transfer |
| head_valid | output | 1 | FIFO holds at least one completed event |
| head_addr | output | ADDR_W | Start address of the oldest event |
| head_len | output | ADDR_W+1 | Total length of the oldest event |

## Verification
The directed patterns start with single-transfer events packed from address zero. A split event follows, which tells a held start address and a summed length apart from per-transfer bookkeeping. The FIFO is then filled so that a closing transfer is refused while a continuation is still granted. Further patterns check that an event crossing the main/overflow boundary wraps both the write and the release pointers, and that refusals against the physical end are kept distinct from refusals against the oldest live event. A long random mix of requests, split events and releases follows, with every output compared each cycle against a queue-based model.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_FULL  = 2'd2
  } rsp_e;
endpackage

// File: rtl/evbuf_space.sv
// Decides whether a transfer of 'words' fits at the write pointer.
module evbuf_space #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 9,
  parameter int TOTAL  = 3584,
  localparam int SUM_W = ((CNT_W > ADDR_W) ? CNT_W : ADDR_W) + 1
) (
  input  logic [ADDR_W-1:0] wp,
  input  logic [ADDR_W-1:0] rp,
  input  logic              lap,
  input  logic [CNT_W-1:0]  words,
  output logic              fits
);
  logic [SUM_W-1:0] need;

  always_comb begin
    need = SUM_W'(wp) + SUM_W'(words);
    if (lap) fits = (need <= SUM_W'(rp));
    else     fits = (need <= SUM_W'(TOTAL));
  end
endmodule

// File: rtl/evbuf_ptr_fifo.sv
// Read-pointer FIFO: stores {start, length} of completed events.
module evbuf_ptr_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 25,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         is_full
);
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == IDX_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == IDX_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign dout      = mem[rd_q];
  assign not_empty = (lvl_q != '0);
  assign is_full   = (lvl_q == LVL_W'(DEPTH));
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr
  import evbuf_pkg::*;
#(
  parameter int MAIN_WORDS = 3072,
  parameter int OVF_WORDS  = 512,
  parameter int CNT_W      = 9,
  parameter int FIFO_DEPTH = 16,
  localparam int TOTAL  = MAIN_WORDS + OVF_WORDS,
  localparam int ADDR_W = $clog2(TOTAL + 1),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic              xfer_more,
  input  logic              rel,
  output logic              grant,
  output logic              full,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              head_valid,
  output logic [ADDR_W-1:0] head_addr,
  output logic [LEN_W-1:0]  head_len
);
  localparam int ENT_W = ADDR_W + LEN_W;

  logic [ADDR_W-1:0] wp_q, rp_q, ev_start_q, start_c;
  logic [LEN_W-1:0]  ev_sum_q, sum_c, end_w, end_r;
  logic              lap_q, in_ev_q, lap_d;
  logic              fits, fifo_full, fifo_ne;
  logic              accept, push, pop, wrap_w, wrap_r;
  logic [ENT_W-1:0]  push_word, head_word;
  rsp_e              rsp;

  evbuf_space #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TOTAL(TOTAL)) u_space (
    .wp(wp_q), .rp(rp_q), .lap(lap_q), .words(xfer_words), .fits(fits)
  );

  evbuf_ptr_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .din(push_word), .dout(head_word), .not_empty(fifo_ne), .is_full(fifo_full)
  );

  always_comb begin
    start_c   = in_ev_q ? ev_start_q : wp_q;
    sum_c     = (in_ev_q ? ev_sum_q : '0) + LEN_W'(xfer_words);
    end_w     = LEN_W'(wp_q) + LEN_W'(xfer_words);
    wrap_w    = (end_w >= LEN_W'(MAIN_WORDS));
    accept    = xfer_valid && fits && (xfer_more || !fifo_full);
    push      = accept && !xfer_more;
    pop       = rel && fifo_ne;
    end_r     = LEN_W'(head_addr) + head_len;
    wrap_r    = (end_r >= LEN_W'(MAIN_WORDS));
    push_word = {start_c, sum_c};
    if (!xfer_valid) rsp = RSP_IDLE;
    else if (accept) rsp = RSP_GRANT;
    else             rsp = RSP_FULL;
    // write wrap needs lap=0, read wrap needs lap=1: never both at once
    lap_d = lap_q;
    if (pop && wrap_r)  lap_d = 1'b0;
    if (push && wrap_w) lap_d = 1'b1;
  end

  assign head_valid = fifo_ne;
  assign head_addr  = head_word[ENT_W-1:LEN_W];
  assign head_len   = head_word[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= 1'b0;
      full       <= 1'b0;
      wr_addr    <= '0;
      wp_q       <= '0;
      rp_q       <= '0;
      lap_q      <= 1'b0;
      in_ev_q    <= 1'b0;
      ev_start_q <= '0;
      ev_sum_q   <= '0;
    end else begin
      grant <= (rsp == RSP_GRANT);
      full  <= (rsp == RSP_FULL);
      lap_q <= lap_d;
      if (accept) begin
        wr_addr <= wp_q;
        if (xfer_more) begin
          in_ev_q    <= 1'b1;
          ev_start_q <= start_c;
          ev_sum_q   <= sum_c;
          wp_q       <= end_w[ADDR_W-1:0];
        end else begin
          in_ev_q <= 1'b0;
          wp_q    <= wrap_w ? '0 : end_w[ADDR_W-1:0];
        end
      end
      if (pop) rp_q <= wrap_r ? '0 : end_r[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/evbuf_mgr_chk.sv
module evbuf_mgr_chk #(
  parameter int MAIN_WORDS = 3072,
  parameter int OVF_WORDS  = 512,
  parameter int CNT_W      = 9,
  localparam int TOTAL  = MAIN_WORDS + OVF_WORDS,
  localparam int ADDR_W = $clog2(TOTAL + 1),
  localparam int LEN_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid,
  input logic [CNT_W-1:0]  xfer_words,
  input logic              rel,
  input logic              grant,
  input logic              full,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              head_valid,
  input logic [ADDR_W-1:0] head_addr,
  input logic [LEN_W-1:0]  head_len
);
  // R9
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> (grant ^ full));
  // R9
  resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_valid |=> (!grant && !full));
  // R5
  fit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> (int'(wr_addr) + int'($past(xfer_words)) <= TOTAL));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_valid |=> $stable(wr_addr));
  // R8
  empty_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel && !head_valid && !xfer_valid) |=> !head_valid);
  // R7
  head_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(head_valid) |-> $past(rel));
  // R7
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !rel) |=> (head_valid && $stable(head_addr) && $stable(head_len)));
endmodule

bind evbuf_mgr evbuf_mgr_chk #(
  .MAIN_WORDS(MAIN_WORDS), .OVF_WORDS(OVF_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_words(xfer_words),
  .rel(rel), .grant(grant), .full(full), .wr_addr(wr_addr),
  .head_valid(head_valid), .head_addr(head_addr), .head_len(head_len)
);

// File: tb/evbuf_mgr_bench.sv
`timescale 1ns/1ps
module evbuf_mgr_bench;
  localparam int MAIN  = 64;
  localparam int OVF   = 32;
  localparam int CW    = 6;
  localparam int DEP   = 4;
  localparam int TOTAL = MAIN + OVF;
  localparam int AW    = $clog2(TOTAL + 1);
  localparam int LW    = AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_valid = 1'b0;
  logic [CW-1:0] xfer_words = '0;
  logic          xfer_more = 1'b0;
  logic          rel = 1'b0;
  logic          grant, full, head_valid;
  logic [AW-1:0] wr_addr, head_addr;
  logic [LW-1:0] head_len;

  evbuf_mgr #(.MAIN_WORDS(MAIN), .OVF_WORDS(OVF), .CNT_W(CW), .FIFO_DEPTH(DEP)) u_evbuf_mgr (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_words(xfer_words),
    .xfer_more(xfer_more), .rel(rel), .grant(grant), .full(full),
    .wr_addr(wr_addr), .head_valid(head_valid), .head_addr(head_addr), .head_len(head_len)
  );

  always #2.5 clk = ~clk;

  int    tests = 0, fails = 0;
  string phase = "R1";
  bit    seen_edge = 0, done = 0;

  // reference model
  int m_wp, m_rp, m_lap, m_inev, m_start, m_sum;
  int e_grant, e_full, e_addr;
  int q_s[$], q_l[$];

  always @(posedge clk) begin
    int n, st, sm, endw, endr;
    bit fit, ok;
    seen_edge <= 1'b1;
    if (rst) begin
      m_wp = 0; m_rp = 0; m_lap = 0; m_inev = 0; m_start = 0; m_sum = 0;
      e_grant = 0; e_full = 0; e_addr = 0;
      q_s.delete(); q_l.delete();
    end else begin
      n = int'(xfer_words);
      fit = (m_lap != 0) ? (m_wp + n <= m_rp) : (m_wp + n <= TOTAL);
      ok  = xfer_valid && fit && (xfer_more || q_s.size() < DEP);
      e_grant = (xfer_valid && ok) ? 1 : 0;
      e_full  = (xfer_valid && !ok) ? 1 : 0;
      if (rel && q_s.size() > 0) begin
        endr = q_s[0] + q_l[0];
        void'(q_s.pop_front()); void'(q_l.pop_front());
        if (endr >= MAIN) begin m_rp = 0; m_lap = 0; end
        else m_rp = endr;
      end
      if (ok) begin
        e_addr = m_wp;
        st = m_inev ? m_start : m_wp;
        sm = (m_inev ? m_sum : 0) + n;
        endw = m_wp + n;
        if (xfer_more) begin
          m_inev = 1; m_start = st; m_sum = sm; m_wp = endw;
        end else begin
          m_inev = 0; q_s.push_back(st); q_l.push_back(sm);
          if (endw >= MAIN) begin m_wp = 0; m_lap = 1; end
          else m_wp = endw;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (seen_edge && !done) begin
      chk(phase, "grant", int'(grant), e_grant);
      chk("R9", "full", int'(full), e_full);
      chk(phase, "wr_addr", int'(wr_addr), e_addr);
      chk("R7", "head_valid", int'(head_valid), (q_s.size() > 0) ? 1 : 0);
      if (q_s.size() > 0) begin
        chk("R7", "head_addr", int'(head_addr), q_s[0]);
        chk("R7", "head_len", int'(head_len), q_l[0]);
      end
    end
  end

  task automatic xfer(input int n, input bit more);
    xfer_valid = 1'b1; xfer_words = CW'(n); xfer_more = more;
    @(negedge clk);
    xfer_valid = 1'b0; xfer_more = 1'b0;
  endtask

  task automatic release_one();
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "grant in reset", int'(grant), 0);
    chk("R1", "head_valid in reset", int'(head_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "wr_addr after reset", int'(wr_addr), 0);
    chk("R1", "full after reset", int'(full), 0);

    phase = "R2";
    xfer(10, 0);  chk("R2", "first addr", int'(wr_addr), 0);
    xfer(5, 0);   chk("R2", "packed addr", int'(wr_addr), 10);

    phase = "R3";
    xfer(20, 1);  chk("R3", "part1 addr", int'(wr_addr), 15);
    xfer(8, 0);   chk("R3", "part2 addr", int'(wr_addr), 35);

    phase = "R6";
    xfer(3, 0);   chk("R6", "fourth event grant", int'(grant), 1);
    xfer(2, 0);   chk("R6", "fifo full refuses", int'(full), 1);
    xfer(2, 1);   chk("R6", "continuation granted", int'(wr_addr), 46);
    xfer(1, 0);   chk("R6", "closing refused", int'(full), 1);
    phase = "R8";
    release_one(); chk("R8", "head after release", int'(head_addr), 10);
    phase = "R3";
    xfer(1, 0);   chk("R3", "split close addr", int'(wr_addr), 48);
    phase = "R8";
    release_one(); chk("R3", "split head len", int'(head_len), 28);

    phase = "R4";
    xfer(20, 0);  chk("R4", "crossing event addr", int'(wr_addr), 49);

    phase = "R5";
    xfer(16, 0);  chk("R6", "full again", int'(full), 1);
    release_one();
    xfer(44, 0);  chk("R5", "overlaps live data", int'(full), 1);
    xfer(43, 0);  chk("R4", "wrapped to base", int'(wr_addr), 0);
    release_one(); release_one(); release_one();
    chk("R8", "head after read wrap", int'(head_addr), 0);
    xfer(60, 0);  chk("R5", "past physical end", int'(full), 1);
    xfer(53, 0);  chk("R5", "fills to end", int'(wr_addr), 43);

    phase = "R8";
    release_one(); release_one();
    chk("R8", "empty after releases", int'(head_valid), 0);
    release_one();
    chk("R8", "empty release ignored", int'(head_valid), 0);
    xfer(7, 0);   chk("R8", "space reclaimed", int'(wr_addr), 0);
    release_one();

    phase = "R7";
    for (int i = 0; i < 600; i++) begin
      xfer_valid = ($urandom_range(0, 1) == 1);
      xfer_words = CW'($urandom_range(0, 40));
      xfer_more  = ($urandom_range(0, 3) == 0);
      rel        = ($urandom_range(0, 9) < 4);
      @(negedge clk);
    end
    xfer_valid = 1'b0; xfer_more = 1'b0; rel = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule